// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns a single column command into the ordered list of column addresses that one synchronous-DRAM burst touches. When a command strobe arrives, it latches the start column, the burst-length code and the ordering select. From the next clock onward it presents one column per cycle, together with a valid strobe and a flag that marks the final beat. A memory controller uses the stream to steer its data path. A behavioural memory model uses it to decide which storage word each data beat reads or writes.

Fixed bursts of 1, 2, 4 or 8 words stay inside a block of columns aligned to the burst length. Within that block the order is either sequential (counting up with wraparound) or interleaved (the start offset XOR the beat number). A full-page burst walks the whole row in sequential order, wrapping from the top column to zero, and runs until a terminate input stops it. A new command always cuts off the burst in progress and restarts from its own column.

Top module: `burst_col_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `col_valid` and `col_last` low.
- R2: A `start` sampled at a rising edge makes the following cycle carry `col_valid` high and `col_addr` equal to the sampled `start_col`; after that, one new column appears per clock.
- R3: `bl_code` 3'b000, 3'b001, 3'b010 and 3'b011 select bursts of 1, 2, 4 and 8 beats; 3'b111 selects full page.
- R4: With `ilv_sel` low, beat k of a fixed burst of length BL has its low log2(BL) bits equal to (start low bits + k) mod BL, and its upper bits equal to those of the start column.
- R5: With `ilv_sel` high, beat k of a fixed burst has its low log2(BL) bits equal to the start low bits XOR k, and its upper bits unchanged.
- R6: `col_last` is high on beat BL-1 of a fixed burst, and `col_valid` is low in the cycle after that, unless a new `start` was sampled.
- R7: A full-page burst gives start, start+1, … modulo 2^COL_W, wrapping from the top column to 0. It never raises `col_last` on its own.
- R8: `stop` high during a valid beat raises `col_last` in that same cycle and ends the burst at the next edge.
- R9: A `start` during a burst abandons it and begins the new sequence in the next cycle; `start` takes precedence over a simultaneous `stop`.
- R10: Reserved `bl_code` values 3'b100, 3'b101 and 3'b110 give a burst of one beat.
- R11: With full page selected, `ilv_sel` is ignored and the order is sequential.
- R12: `col_last` is never high without `col_valid`; `stop` while idle leaves `col_valid` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Column command strobe; loads a new burst |
| start_col | input | COL_W | Starting column of the burst |
| bl_code | input | 3 | Burst-length code (see R3, R10) |
| ilv_sel | input | 1 | 1 selects interleaved ordering for fixed bursts |
| stop | input | 1 | Burst terminate |
| col_valid | output | 1 | A column is presented this cycle |
| col_addr | output | COL_W | Current column address |
| col_last | output | 1 | Current beat is the final one |

## Verification
The first column is due in the cycle after the edge that samples `start`. Each later column is due exactly one clock after the one before it. A terminate shows up on `col_last` in the same cycle as `stop`, and `col_valid` drops one edge later. The bench drives every input just after a falling edge and compares the outputs one time unit later, on every clock, against a behavioural model. That model advances once per edge using the same inputs. This keeps both the same-cycle `stop` response and the one-edge-later response aligned to their due cycles.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

    typedef enum logic [2:0] {
        BLC_ONE  = 3'b000,
        BLC_TWO  = 3'b001,
        BLC_FOUR = 3'b010,
        BLC_EIGHT = 3'b011,
        BLC_PAGE = 3'b111
    } bl_code_e;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_ILV = 1'b1
    } order_e;

    typedef struct packed {
        order_e     order;
        logic       full_page;
        logic [1:0] len_log2;
    } burst_cfg_t;

    function automatic burst_cfg_t decode_cfg(input logic [2:0] code, input logic ilv);
        burst_cfg_t c;
        c.full_page = 1'b0;
        c.order     = ilv ? ORD_ILV : ORD_SEQ;
        case (code)
            BLC_TWO:   c.len_log2 = 2'd1;
            BLC_FOUR:  c.len_log2 = 2'd2;
            BLC_EIGHT: c.len_log2 = 2'd3;
            BLC_PAGE: begin
                c.len_log2  = 2'd0;
                c.full_page = 1'b1;
                c.order     = ORD_SEQ;
            end
            default:   c.len_log2 = 2'd0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/burst_cfg_decode.sv
module burst_cfg_decode
    import burst_col_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic [2:0]       bl_code,
    input  logic             ilv_sel,
    output burst_cfg_t       cfg,
    output logic [COL_W-1:0] wrap_mask
);
    always_comb cfg = decode_cfg(bl_code, ilv_sel);

    for (genvar i = 0; i < COL_W; i++) begin : g_mask
        assign wrap_mask[i] = cfg.full_page || (i < int'(cfg.len_log2));
    end
endmodule

// File: rtl/burst_seq_counter.sv
module burst_seq_counter
    import burst_col_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             stop,
    input  logic [COL_W-1:0] start_col,
    input  burst_cfg_t       cfg_in,
    input  logic [COL_W-1:0] mask_in,
    output logic             active,
    output logic             last,
    output logic [COL_W-1:0] base_q,
    output logic [COL_W-1:0] beat_q,
    output logic [COL_W-1:0] mask_q,
    output burst_cfg_t       cfg_q
);
    logic natural_end;

    assign natural_end = !cfg_q.full_page && (beat_q == mask_q);
    assign last        = active && (stop || natural_end);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            beat_q <= '0;
            base_q <= '0;
            mask_q <= '0;
            cfg_q  <= '0;
        end else if (start) begin
            active <= 1'b1;
            beat_q <= '0;
            base_q <= start_col;
            mask_q <= mask_in;
            cfg_q  <= cfg_in;
        end else if (active) begin
            if (last) begin
                active <= 1'b0;
            end else begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map
    import burst_col_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] beat,
    input  logic [COL_W-1:0] mask,
    input  burst_cfg_t       cfg,
    output logic [COL_W-1:0] addr
);
    logic [COL_W-1:0] seq_low;
    logic [COL_W-1:0] ilv_low;

    assign seq_low = (base + beat) & mask;
    assign ilv_low = (base ^ beat) & mask;

    always_comb begin
        if (cfg.order == ORD_ILV) addr = (base & ~mask) | ilv_low;
        else                      addr = (base & ~mask) | seq_low;
    end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import burst_col_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic [2:0]       bl_code,
    input  logic             ilv_sel,
    input  logic             stop,
    output logic             col_valid,
    output logic [COL_W-1:0] col_addr,
    output logic             col_last
);
    burst_cfg_t       cfg_new, cfg_cur;
    logic [COL_W-1:0] mask_new, mask_cur, base_cur, beat_cur;

    burst_cfg_decode #(.COL_W(COL_W)) u_dec (
        .bl_code  (bl_code),
        .ilv_sel  (ilv_sel),
        .cfg      (cfg_new),
        .wrap_mask(mask_new)
    );

    burst_seq_counter #(.COL_W(COL_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .stop     (stop),
        .start_col(start_col),
        .cfg_in   (cfg_new),
        .mask_in  (mask_new),
        .active   (col_valid),
        .last     (col_last),
        .base_q   (base_cur),
        .beat_q   (beat_cur),
        .mask_q   (mask_cur),
        .cfg_q    (cfg_cur)
    );

    burst_addr_map #(.COL_W(COL_W)) u_map (
        .base(base_cur),
        .beat(beat_cur),
        .mask(mask_cur),
        .cfg (cfg_cur),
        .addr(col_addr)
    );
endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
    parameter int COL_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [COL_W-1:0] start_col,
    input logic             stop,
    input logic             col_valid,
    input logic [COL_W-1:0] col_addr,
    input logic             col_last
);
    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (!col_valid && !col_last)); // R1
    AST_START_FIRST: assert property (@(posedge clk) disable iff (rst)
        start |=> (col_valid && col_addr == $past(start_col))); // R2
    AST_END_DROP: assert property (@(posedge clk) disable iff (rst)
        (col_last && !start) |=> !col_valid); // R6
    AST_KEEP_GOING: assert property (@(posedge clk) disable iff (rst)
        (col_valid && !col_last && !start) |=> col_valid); // R7
    AST_STOP_LAST: assert property (@(posedge clk) disable iff (rst)
        (col_valid && stop) |-> col_last); // R8
    AST_LAST_VALID: assert property (@(posedge clk) disable iff (rst)
        col_last |-> col_valid); // R12
    AST_IDLE_STAY: assert property (@(posedge clk) disable iff (rst)
        (!col_valid && !start) |=> !col_valid); // R12
endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (.*);

// File: tb/burst_col_gen_tb.sv
module burst_col_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int COL_W = 10;
    localparam int NCOL = 1 << COL_W;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [COL_W-1:0] start_col = '0;
    logic [2:0]       bl_code = '0;
    logic             ilv_sel = 1'b0;
    logic             stop = 1'b0;
    logic             col_valid;
    logic [COL_W-1:0] col_addr;
    logic             col_last;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    bit done = 0;

    // behavioural model state
    bit m_active = 0;
    int m_base = 0, m_k = 0, m_len = 1;
    bit m_ilv = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_col_gen #(.COL_W(COL_W)) u_dut (
        .clk(clk), .rst(rst), .start(start), .start_col(start_col),
        .bl_code(bl_code), .ilv_sel(ilv_sel), .stop(stop),
        .col_valid(col_valid), .col_addr(col_addr), .col_last(col_last)
    );

    function automatic int len_of(input logic [2:0] c);
        case (c)
            3'b001: return 2;
            3'b010: return 4;
            3'b011: return 8;
            3'b111: return 0;
            default: return 1;
        endcase
    endfunction

    function automatic int exp_addr();
        int blk;
        if (m_len == 0) return (m_base + m_k) % NCOL;
        blk = (m_base / m_len) * m_len;
        if (m_ilv) return blk + ((m_base % m_len) ^ m_k);
        return blk + ((m_base % m_len) + m_k) % m_len;
    endfunction

    function automatic bit exp_last();
        return m_active && (stop || (m_len != 0 && m_k == m_len - 1));
    endfunction

    task automatic check_outputs();
        checks++;
        if (col_valid !== m_active) begin
            errors++;
            $display("FAIL %s: col_valid=%0b expected %0b at %0t", cur_req, col_valid, m_active, $time);
        end
        checks++;
        if (col_last !== exp_last()) begin
            errors++;
            $display("FAIL %s: col_last=%0b expected %0b at %0t", cur_req, col_last, exp_last(), $time);
        end
        if (m_active) begin
            checks++;
            if (int'(col_addr) != exp_addr()) begin
                errors++;
                $display("FAIL %s: col_addr=%0d expected %0d at %0t", cur_req, col_addr, exp_addr(), $time);
            end
        end
    endtask

    task automatic model_edge();
        bit lst;
        lst = exp_last();
        if (rst) begin
            m_active = 0;
        end else if (start) begin
            m_active = 1;
            m_base = int'(start_col);
            m_k = 0;
            m_len = len_of(bl_code);
            m_ilv = ilv_sel && (m_len != 0);
        end else if (m_active) begin
            if (lst) m_active = 0;
            else m_k = (m_k + 1) % NCOL;
        end
    endtask

    task automatic step(input bit st, input int col, input logic [2:0] code,
                        input bit il, input bit sp);
        start = st;
        start_col = COL_W'(col);
        bl_code = code;
        ilv_sel = il;
        stop = sp;
        #1;
        check_outputs();
        model_edge();
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 3'b000, 0, 0);
    endtask

    initial begin
        @(negedge clk);
        cur_req = "R1";
        rst = 1'b1;
        for (int i = 0; i < 3; i++) step(0, 0, 3'b000, 0, 0);
        rst = 1'b0;
        idle(2);

        cur_req = "R4"; // sequential BL4 from mid block: 0xA6,0xA7,0xA4,0xA5
        step(1, 'hA6, 3'b010, 0, 0);
        idle(5);

        cur_req = "R3"; // BL1, BL2, BL8 sequential
        step(1, 'h35, 3'b000, 0, 0);
        idle(2);
        step(1, 'h35, 3'b001, 0, 0);
        idle(3);
        cur_req = "R6";
        step(1, 'h1F3, 3'b011, 0, 0);
        idle(10);

        cur_req = "R5"; // interleaved BL8 and BL4
        step(1, 'h2D, 3'b011, 1, 0);
        idle(10);
        step(1, 'h3FE, 3'b010, 1, 0);
        idle(6);
        step(1, 'h101, 3'b001, 1, 0);
        idle(3);

        cur_req = "R7"; // full page wrapping past the top column
        step(1, NCOL - 3, 3'b111, 0, 0);
        idle(8);
        cur_req = "R8";
        step(0, 0, 3'b000, 0, 1);
        idle(3);

        cur_req = "R7"; // long full-page run covering a whole row
        step(1, 'h200, 3'b111, 0, 0);
        idle(NCOL + 5);
        cur_req = "R8";
        step(0, 0, 3'b000, 0, 1);
        idle(2);

        cur_req = "R8"; // terminate a fixed burst early
        step(1, 'h40, 3'b011, 0, 0);
        idle(2);
        step(0, 0, 3'b000, 0, 1);
        idle(3);

        cur_req = "R9"; // interrupt, and start beating stop in same cycle
        step(1, 'h10, 3'b011, 0, 0);
        idle(2);
        step(1, 'h2A2, 3'b010, 1, 0);
        idle(1);
        step(1, 'h77, 3'b001, 0, 1);
        idle(4);
        step(1, 'h300, 3'b111, 0, 0);
        idle(3);
        step(1, 'h05, 3'b010, 0, 0);
        idle(5);

        cur_req = "R10"; // reserved codes give one beat
        step(1, 'h123, 3'b100, 0, 0);
        idle(2);
        step(1, 'h124, 3'b101, 1, 0);
        idle(2);
        step(1, 'h125, 3'b110, 0, 0);
        idle(2);

        cur_req = "R11"; // full page with interleave select stays sequential
        step(1, 'h0D, 3'b111, 1, 0);
        idle(6);
        step(0, 0, 3'b000, 0, 1);
        idle(2);

        cur_req = "R12"; // stop while idle has no effect
        step(0, 0, 3'b000, 0, 1);
        step(0, 0, 3'b000, 0, 1);
        idle(3);

        cur_req = "R2"; // back-to-back single beats
        step(1, 'h3FF, 3'b000, 0, 0);
        step(1, 'h000, 3'b000, 0, 0);
        step(1, 'h155, 3'b011, 1, 0);
        idle(10);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule